// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block computes the processor state that an exception-class event installs. A single-cycle strobe carries the event kind, an event code, the faulting virtual page number and a trap number. The caller also supplies the live status word, stack pointer, vector base and page-table-entry-high value. One clock later the block presents the new program counter, the next program counter, the status word, the saved status and saved stack pointer, and the vector base. In the same cycle it pulses write enables, with data, for the event-code, interrupt-code, trap-number, fault-address and page-table-high registers, and it pulses a clear of the delay-slot flag.

The supported kinds are explicit reset, general exception, trap, TLB exception, TLB multi-hit and accepted interrupt. Resets restart at a fixed address with the vector base cleared. Every other kind saves context and jumps to the caller's vector base plus an offset chosen by its class. A general exception raised while exceptions are blocked is turned into a manual reset. Interrupt arbitration and address translation are done by neighbouring blocks.

Top module: `exc_entry_seq`

## Requirements
- R1: After the synchronous reset `rst` the outputs hold pc 0xA0000000, npc 0xA0000002, vbr 0, sr 0x700000F0, fpscr 0x00040001. ssr, sgr and all register-write data are 0, and no write strobe or delay-slot clear is active.
- R2: Kind 0 (reset) sets pc 0xA0000000 and vbr 0. It sets sr to (sr_in with bits 30, 29, 28 and 7:4 set) with bit 15 cleared, and writes ev_code to the event-code register. ssr and sgr stay unchanged.
- R3: Kind 1 (general exception) with sr_in bit 28 clear copies sr_in to ssr and r15_in to sgr. It sets sr to sr_in with bits 30, 29 and 28 set, sets pc to vbr_in+0x100 and vbr to vbr_in, and writes ev_code to the event-code register.
- R4: Kind 1 with sr_in bit 28 set acts as R2, except that the event-code register gets the manual-reset code 0x020.
- R5: Kind 2 (trap) saves context as R3, sets pc to vbr_in+0x100, writes ev_trapno shifted left by 2 to the trap register, and writes the trap code 0x160 to the event-code register.
- R6: Kind 3 (TLB exception) saves context as R3, sets pc to vbr_in+0x400, and writes ev_code to the event-code register. It writes ev_vpn to the fault-address register and {ev_vpn[31:10], pteh_in[9:0]} to the page-table-high register.
- R7: Kind 4 (TLB multi-hit) writes the fault-address and page-table-high registers as R6, then resets as R2 with ev_code as its event code.
- R8: Kind 5 (interrupt) saves context as R3, sets pc to vbr_in+0x600, and writes ev_code to the interrupt-code register only. The event-code register is not written.
- R9: Every accepted event gives npc = pc+2 and a one-cycle delay-slot clear. Each write strobe is high for exactly the one cycle after its event.
- R10: Kinds 6 and 7, and cycles with ev_valid low, change no output and raise no strobe.
- R11: Results appear in the cycle after the strobe. `rst` overrides a simultaneous event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ev_valid | input | 1 | event strobe |
| ev_kind | input | 3 | event kind (0..5 used) |
| ev_code | input | 12 | event or interrupt code |
| ev_vpn | input | 32 | faulting virtual page address |
| ev_trapno | input | 8 | trap number |
| sr_in | input | 32 | current status word |
| r15_in | input | 32 | current stack pointer |
| vbr_in | input | 32 | current vector base |
| pteh_in | input | 32 | current page-table-entry-high |
| pc_o | output | 32 | new program counter |
| npc_o | output | 32 | next program counter |
| sr_o | output | 32 | new status word |
| ssr_o | output | 32 | saved status word |
| sgr_o | output | 32 | saved stack pointer |
| vbr_o | output | 32 | vector base |
| fpscr_o | output | 32 | floating-point control after power-on |
| expevt_we | output | 1 | event-code register write |
| expevt_o | output | 12 | event-code data |
| intevt_we | output | 1 | interrupt-code register write |
| intevt_o | output | 12 | interrupt-code data |
| tra_we | output | 1 | trap register write |
| tra_o | output | 32 | trap register data |
| tea_we | output | 1 | fault-address register write |
| tea_o | output | 32 | fault-address data |
| pteh_we | output | 1 | page-table-high register write |
| pteh_o | output | 32 | page-table-high data |
| dslot_clr | output | 1 | clear delay-slot flag |

## Verification
A wrong class decode would show one cycle after the strobe as a wrong vector in pc_o, or as the wrong strobe raised (interrupt code written to the event register, or a fault address written on a trap). A missed blocked-state check would show as a context save where a jump to the fixed reset address was expected. A stale saved-context or data register would show only at the next event of a kind that writes it, so every output is compared on every cycle, including idle cycles.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int SR_MD_B = 30;
  localparam int SR_RB_B = 29;
  localparam int SR_BL_B = 28;
  localparam int SR_FD_B = 15;
  localparam logic [31:0] SR_IMASK = 32'h0000_00F0;
  localparam logic [31:0] SR_ENTRY = 32'h7000_0000;
  localparam logic [31:0] RESET_PC = 32'hA000_0000;
  localparam logic [31:0] PON_SR = 32'h7000_00F0;
  localparam logic [31:0] PON_FPSCR = 32'h0004_0001;
  localparam logic [11:0] OFF_GENERAL = 12'h100;
  localparam logic [11:0] OFF_TLB = 12'h400;
  localparam logic [11:0] OFF_IRQ = 12'h600;

  typedef enum logic [2:0] {
    EV_RESET = 3'd0, EV_GENERAL = 3'd1, EV_TRAP = 3'd2,
    EV_TLB = 3'd3, EV_MULTIHIT = 3'd4, EV_IRQ = 3'd5
  } ev_kind_e;

  typedef struct packed {
    logic accept;
    logic to_reset;
    logic manual;
    logic save_ctx;
    logic wr_exp;
    logic wr_int;
    logic wr_tra;
    logic wr_tea;
    logic [11:0] vec_off;
  } ev_class_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       blocked,
  output ev_class_t  cls
);
  always_comb begin
    cls = '0;
    case (kind)
      EV_RESET: begin
        cls.accept = 1'b1; cls.to_reset = 1'b1; cls.wr_exp = 1'b1;
      end
      EV_GENERAL: begin
        cls.accept = 1'b1; cls.wr_exp = 1'b1;
        if (blocked) begin
          cls.to_reset = 1'b1; cls.manual = 1'b1;
        end else begin
          cls.save_ctx = 1'b1; cls.vec_off = OFF_GENERAL;
        end
      end
      EV_TRAP: begin
        cls.accept = 1'b1; cls.save_ctx = 1'b1; cls.wr_exp = 1'b1;
        cls.wr_tra = 1'b1; cls.vec_off = OFF_GENERAL;
      end
      EV_TLB: begin
        cls.accept = 1'b1; cls.save_ctx = 1'b1; cls.wr_exp = 1'b1;
        cls.wr_tea = 1'b1; cls.vec_off = OFF_TLB;
      end
      EV_MULTIHIT: begin
        cls.accept = 1'b1; cls.to_reset = 1'b1; cls.wr_exp = 1'b1;
        cls.wr_tea = 1'b1;
      end
      EV_IRQ: begin
        cls.accept = 1'b1; cls.save_ctx = 1'b1; cls.wr_int = 1'b1;
        cls.vec_off = OFF_IRQ;
      end
      default: cls = '0;
    endcase
  end
endmodule

// File: rtl/exc_next_state.sv
module exc_next_state
  import exc_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CODE_W      = 12,
  parameter int TRAP_W      = 8,
  parameter int PAGE_BITS   = 10,
  parameter logic [11:0] MANUAL_CODE = 12'h020,
  parameter logic [11:0] TRAP_CODE   = 12'h160
) (
  input  ev_class_t         cls,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   vpn,
  input  logic [TRAP_W-1:0] trapno,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   pteh_in,
  output logic [XLEN-1:0]   n_pc,
  output logic [XLEN-1:0]   n_sr,
  output logic [XLEN-1:0]   n_vbr,
  output logic [CODE_W-1:0] n_exp,
  output logic [XLEN-1:0]   n_tra,
  output logic [XLEN-1:0]   n_pteh
);
  localparam logic [XLEN-1:0] FD_MASK = XLEN'(1) << SR_FD_B;
  localparam logic [XLEN-1:0] RST_SET = XLEN'(SR_ENTRY | SR_IMASK);

  always_comb begin
    if (cls.to_reset) begin
      n_pc  = XLEN'(RESET_PC);
      n_vbr = '0;
      n_sr  = (sr_in | RST_SET) & ~FD_MASK;
    end else begin
      n_pc  = vbr_in + XLEN'(cls.vec_off);
      n_vbr = vbr_in;
      n_sr  = sr_in | XLEN'(SR_ENTRY);
    end
    if (cls.manual)      n_exp = CODE_W'(MANUAL_CODE);
    else if (cls.wr_tra) n_exp = CODE_W'(TRAP_CODE);
    else                 n_exp = code;
    n_tra  = XLEN'(trapno) << 2;
    n_pteh = {vpn[XLEN-1:PAGE_BITS], pteh_in[PAGE_BITS-1:0]};
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 12,
  parameter int TRAP_W    = 8,
  parameter int PAGE_BITS = 10,
  parameter logic [11:0] MANUAL_CODE = 12'h020,
  parameter logic [11:0] TRAP_CODE   = 12'h160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [XLEN-1:0]   ev_vpn,
  input  logic [TRAP_W-1:0] ev_trapno,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   pteh_in,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   vbr_o,
  output logic [XLEN-1:0]   fpscr_o,
  output logic              expevt_we,
  output logic [CODE_W-1:0] expevt_o,
  output logic              intevt_we,
  output logic [CODE_W-1:0] intevt_o,
  output logic              tra_we,
  output logic [XLEN-1:0]   tra_o,
  output logic              tea_we,
  output logic [XLEN-1:0]   tea_o,
  output logic              pteh_we,
  output logic [XLEN-1:0]   pteh_o,
  output logic              dslot_clr
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(2);

  ev_class_t cls;
  logic [XLEN-1:0]   n_pc, n_sr, n_vbr, n_tra, n_pteh;
  logic [CODE_W-1:0] n_exp;
  logic              go;

  exc_classify u_cls (
    .kind(ev_kind), .blocked(sr_in[SR_BL_B]), .cls(cls)
  );

  exc_next_state #(
    .XLEN(XLEN), .CODE_W(CODE_W), .TRAP_W(TRAP_W), .PAGE_BITS(PAGE_BITS),
    .MANUAL_CODE(MANUAL_CODE), .TRAP_CODE(TRAP_CODE)
  ) u_next (
    .cls(cls), .code(ev_code), .vpn(ev_vpn), .trapno(ev_trapno),
    .sr_in(sr_in), .vbr_in(vbr_in), .pteh_in(pteh_in),
    .n_pc(n_pc), .n_sr(n_sr), .n_vbr(n_vbr), .n_exp(n_exp),
    .n_tra(n_tra), .n_pteh(n_pteh)
  );

  assign go = ev_valid && cls.accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= XLEN'(RESET_PC);
      npc_o     <= XLEN'(RESET_PC) + PC_STEP;
      sr_o      <= XLEN'(PON_SR);
      vbr_o     <= '0;
      fpscr_o   <= XLEN'(PON_FPSCR);
      ssr_o     <= '0;
      sgr_o     <= '0;
      expevt_o  <= '0;
      intevt_o  <= '0;
      tra_o     <= '0;
      tea_o     <= '0;
      pteh_o    <= '0;
      expevt_we <= 1'b0;
      intevt_we <= 1'b0;
      tra_we    <= 1'b0;
      tea_we    <= 1'b0;
      pteh_we   <= 1'b0;
      dslot_clr <= 1'b0;
    end else begin
      expevt_we <= go && cls.wr_exp;
      intevt_we <= go && cls.wr_int;
      tra_we    <= go && cls.wr_tra;
      tea_we    <= go && cls.wr_tea;
      pteh_we   <= go && cls.wr_tea;
      dslot_clr <= go;
      if (go) begin
        pc_o  <= n_pc;
        npc_o <= n_pc + PC_STEP;
        sr_o  <= n_sr;
        vbr_o <= n_vbr;
        if (cls.save_ctx) begin
          ssr_o <= sr_in;
          sgr_o <= r15_in;
        end
        if (cls.wr_exp) expevt_o <= n_exp;
        if (cls.wr_int) intevt_o <= ev_code;
        if (cls.wr_tra) tra_o    <= n_tra;
        if (cls.wr_tea) begin
          tea_o  <= ev_vpn;
          pteh_o <= n_pteh;
        end
      end
    end
  end

  AST_ENTRY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (expevt_we || intevt_we) |-> sr_o[SR_BL_B] && sr_o[SR_MD_B]); // R3
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (rst)
    (expevt_we || intevt_we) |-> (npc_o == pc_o + PC_STEP) && dslot_clr); // R9
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == EV_IRQ) |=>
      intevt_we && !expevt_we && (pc_o == $past(vbr_in) + XLEN'(OFF_IRQ))); // R8
  AST_TRAP_NO_TEA: assert property (@(posedge clk) disable iff (rst)
    tra_we |-> !tea_we && (expevt_o == CODE_W'(TRAP_CODE))); // R5
  AST_NESTED_RESET: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == EV_GENERAL && sr_in[SR_BL_B]) |=>
      (pc_o == XLEN'(RESET_PC)) && (expevt_o == CODE_W'(MANUAL_CODE))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !expevt_we && !intevt_we && !dslot_clr && $stable(pc_o)); // R10
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_o == XLEN'(RESET_PC)) && !expevt_we && !dslot_clr); // R11
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [11:0] ev_code = '0;
  logic [31:0] ev_vpn = '0;
  logic [7:0] ev_trapno = '0;
  logic [31:0] sr_in = '0, r15_in = '0, vbr_in = '0, pteh_in = '0;
  logic [31:0] pc_o, npc_o, sr_o, ssr_o, sgr_o, vbr_o, fpscr_o;
  logic expevt_we, intevt_we, tra_we, tea_we, pteh_we, dslot_clr;
  logic [11:0] expevt_o, intevt_o;
  logic [31:0] tra_o, tea_o, pteh_o;

  int total = 0;
  int bad = 0;

  logic [31:0] e_pc, e_npc, e_sr, e_ssr, e_sgr, e_vbr, e_fpscr, e_tra, e_tea, e_pteh;
  logic [11:0] e_exp, e_int;
  logic e_expwe, e_intwe, e_trawe, e_teawe, e_dsl;
  string tag;

  always #10 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_code(ev_code), .ev_vpn(ev_vpn), .ev_trapno(ev_trapno),
    .sr_in(sr_in), .r15_in(r15_in), .vbr_in(vbr_in), .pteh_in(pteh_in),
    .pc_o(pc_o), .npc_o(npc_o), .sr_o(sr_o), .ssr_o(ssr_o), .sgr_o(sgr_o),
    .vbr_o(vbr_o), .fpscr_o(fpscr_o), .expevt_we(expevt_we),
    .expevt_o(expevt_o), .intevt_we(intevt_we), .intevt_o(intevt_o),
    .tra_we(tra_we), .tra_o(tra_o), .tea_we(tea_we), .tea_o(tea_o),
    .pteh_we(pteh_we), .pteh_o(pteh_o), .dslot_clr(dslot_clr)
  );

  function automatic string kind_tag(input logic v, input logic [2:0] k, input logic bl);
    if (!v) return "R10";
    case (k)
      3'd0: return "R2";
      3'd1: return bl ? "R4" : "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] reset_sr(input logic [31:0] s);
    return (s | 32'h7000_00F0) & ~32'h0000_8000;
  endfunction

  task automatic model_power_on();
    e_pc = 32'hA000_0000; e_npc = 32'hA000_0002; e_sr = 32'h7000_00F0;
    e_vbr = '0; e_fpscr = 32'h0004_0001; e_ssr = '0; e_sgr = '0;
    e_exp = '0; e_int = '0; e_tra = '0; e_tea = '0; e_pteh = '0;
    e_expwe = 0; e_intwe = 0; e_trawe = 0; e_teawe = 0; e_dsl = 0;
  endtask

  task automatic model_step();
    logic rs, man;
    logic [31:0] off;
    e_expwe = 0; e_intwe = 0; e_trawe = 0; e_teawe = 0; e_dsl = 0;
    if (!ev_valid || ev_kind > 3'd5) return;
    man = (ev_kind == 3'd1) && sr_in[28];
    rs  = (ev_kind == 3'd0) || (ev_kind == 3'd4) || man;
    e_dsl = 1;
    e_expwe = (ev_kind != 3'd5);
    e_intwe = (ev_kind == 3'd5);
    e_trawe = (ev_kind == 3'd2);
    e_teawe = (ev_kind == 3'd3) || (ev_kind == 3'd4);
    off = (ev_kind == 3'd3) ? 32'h400 : (ev_kind == 3'd5) ? 32'h600 : 32'h100;
    if (rs) begin
      e_pc = 32'hA000_0000; e_vbr = '0; e_sr = reset_sr(sr_in);
    end else begin
      e_ssr = sr_in; e_sgr = r15_in; e_sr = sr_in | 32'h7000_0000;
      e_vbr = vbr_in; e_pc = vbr_in + off;
    end
    e_npc = e_pc + 32'd2;
    if (e_expwe) e_exp = man ? 12'h020 : (ev_kind == 3'd2) ? 12'h160 : ev_code;
    if (e_intwe) e_int = ev_code;
    if (e_trawe) e_tra = {22'd0, ev_trapno, 2'b00};
    if (e_teawe) begin
      e_tea = ev_vpn; e_pteh = {ev_vpn[31:10], pteh_in[9:0]};
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "pc", pc_o, e_pc);
    chk("R9", "npc", npc_o, e_npc);
    chk(req, "sr", sr_o, e_sr);
    chk(req, "ssr", ssr_o, e_ssr);
    chk(req, "sgr", sgr_o, e_sgr);
    chk(req, "vbr", vbr_o, e_vbr);
    chk("R1", "fpscr", fpscr_o, e_fpscr);
    chk(req, "expevt", {20'd0, expevt_o}, {20'd0, e_exp});
    chk(req, "intevt", {20'd0, intevt_o}, {20'd0, e_int});
    chk(req, "tra", tra_o, e_tra);
    chk(req, "tea", tea_o, e_tea);
    chk(req, "pteh", pteh_o, e_pteh);
    chk("R9", "strobes", {26'd0, expevt_we, intevt_we, tra_we, tea_we, pteh_we, dslot_clr},
        {26'd0, e_expwe, e_intwe, e_trawe, e_teawe, e_teawe, e_dsl});
  endtask

  task automatic fire(input logic v, input logic [2:0] k, input logic [11:0] c,
                      input logic [31:0] vpn, input logic [7:0] t, input logic [31:0] s,
                      input logic [31:0] r15, input logic [31:0] vb, input logic [31:0] pt);
    ev_valid = v; ev_kind = k; ev_code = c; ev_vpn = vpn; ev_trapno = t;
    sr_in = s; r15_in = r15; vbr_in = vb; pteh_in = pt;
    tag = kind_tag(v, k, s[28]);
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R11: reset wins over a simultaneous event
    rst = 1'b1; ev_valid = 1'b1; ev_kind = 3'd1; sr_in = 32'h0; vbr_in = 32'h8C00_0000;
    repeat (3) @(negedge clk);
    model_power_on();
    check_all("R11");
    rst = 1'b0; ev_valid = 1'b0;
    @(negedge clk);
    check_all("R1");
    // directed corners
    fire(1, 3'd1, 12'h1E0, 32'h0, 8'h0, 32'h0000_8301, 32'h8C00_F000, 32'h8C00_0000, 32'h0);
    fire(0, 3'd1, 12'h0, 32'h0, 8'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    fire(1, 3'd1, 12'h1E0, 32'h0, 8'h0, 32'h5000_8003, 32'h1234, 32'h8C00_0000, 32'h0);
    fire(1, 3'd2, 12'h0, 32'h0, 8'hFF, 32'h4000_0000, 32'hAA55, 32'h8000_0000, 32'h0);
    fire(1, 3'd3, 12'h040, 32'hDEAD_BEEF, 8'h0, 32'h0, 32'h77, 32'h0C00_0000, 32'h0000_03A5);
    fire(1, 3'd4, 12'h140, 32'hFFFF_FC00, 8'h0, 32'h0000_8000, 32'h0, 32'h0C00_0000, 32'hFFFF_FFFF);
    fire(1, 3'd5, 12'h320, 32'h0, 8'h0, 32'h4000_00F1, 32'h99, 32'hFFFF_FC00, 32'h0);
    fire(1, 3'd6, 12'hABC, 32'h1, 8'h1, 32'h1, 32'h1, 32'h1, 32'h1);
    fire(1, 3'd7, 12'hABC, 32'h1, 8'h1, 32'h1, 32'h1, 32'h1, 32'h1);
    fire(1, 3'd0, 12'h020, 32'h0, 8'h0, 32'h0000_8000, 32'h0, 32'h1000, 32'h0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic v;
      v = ($urandom % 5) != 0;
      fire(v, 3'($urandom % 8), 12'($urandom), $urandom, 8'($urandom),
           $urandom, $urandom, $urandom, $urandom);
    end
    // R11: reset in the middle of traffic
    ev_valid = 1'b1; ev_kind = 3'd5; rst = 1'b1;
    @(negedge clk);
    model_power_on();
    check_all("R11");
    rst = 1'b0; ev_valid = 1'b0;
    @(negedge clk);
    check_all("R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule